// File: doc/BRIEF.md
# ALU Instruction Bus-Timing Sequencer

This block sits after instruction decode and operand fetch in a CPU core with a 16-bit data bus. It receives the decoded operation (compare, AND, OR, exclusive OR, negate-decimal or register swap), the operand size, and the addressing modes of the source and the destination. From these it chooses one of three execution patterns. Every pattern runs a one-clock ALU evaluation slot first. One instruction-prefetch bus cycle follows. After that come zero, one or two idle bus cycles. The block then signals hand-off to the write-back phase.

Every bus cycle, whether prefetch or idle, lasts a fixed number of clocks (four by default). During a prefetch cycle the address strobe and then the data strobe are driven. During an idle cycle neither strobe is driven.

The sequence starts on a start strobe. The strobe is accepted only when the controller is idle and the operand fetch has completed. An operation outside the supported set, or a reserved size code, causes an error pulse instead of a sequence.

The states are named as follows:
- `S_IDLE`: waiting.
- `S_EVAL`: ALU slot.
- `S_PREF`: prefetch bus cycle.
- `S_GAP`: idle bus cycle.
- `S_WB`: write-back hand-off.
- `S_ERR`: unsupported request.

The transitions are:
- S_IDLE→S_EVAL on an accepted valid start.
- S_IDLE→S_ERR on an accepted invalid start.
- S_EVAL→S_PREF always.
- S_PREF→S_GAP at the end of the bus cycle when idle cycles remain.
- S_PREF→S_WB at the end of the bus cycle when none remain.
- S_GAP→S_GAP at the end of a bus cycle when more than one remains.
- S_GAP→S_WB at the end of the last idle cycle.
- S_WB→S_IDLE always.
- S_ERR→S_IDLE always.

Top module: `alu_bus_seq`

## Requirements
- R1: After reset every output is low and `idle_count` is 0.
- R2: A start is accepted only when the block is idle and `operands_ready` is 1. A start with `operands_ready` at 0 is ignored: `busy` and `alu_eval` stay low.
- R3: After an accepted valid start, the sequence runs as follows. `alu_eval` is high for exactly one clock. Then `prefetch_cyc` is high for 4 clocks. Then `idle_cyc` is high for 4 clocks per idle cycle. Then `done` rises, 6+4n clocks after the start edge, where n is the idle-cycle count.
- R4: Take the prefetch clocks as 1 to 4. `addr_strobe` is high on clocks 2 to 4 and `data_strobe` is high on clocks 3 to 4. During idle cycles both strobes are low.
- R5: Compare (op 0), AND (op 1), OR (op 2) and EOR (op 3) with size byte (0) or word (1) use zero idle cycles.
- R6: Compare with size long (2) uses one idle cycle.
- R7: Long AND and long OR with a data-register destination (mode 0) behave as follows. With a data-register source (mode 0) or immediate source (mode 7) they use two idle cycles. With any other source they use one.
- R8: Long AND, OR and EOR with a destination mode other than 0 use zero idle cycles.
- R9: Long EOR with a data-register destination uses two idle cycles.
- R10: Negate-decimal (op 4) uses one idle cycle when its operand mode (`src_mode`) is 0 and zero otherwise. Swap (op 5) always uses zero.
- R11: `done` is a one-clock pulse, after which `busy` is low. `idle_count` shows the chosen count from the clock after the accepted start until the next accepted start.
- R12: An op code of 6 or 7, or a size of 3, raises `err` for one clock with `busy` high. In that case there is no ALU slot and no bus cycle, and the block is idle on the next clock.
- R13: A start while `busy` is high is ignored and does not change the running sequence's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence |
| operands_ready | input | 1 | Operand fetch has completed |
| op | input | 3 | Operation: 0 CMP, 1 AND, 2 OR, 3 EOR, 4 NBCD, 5 SWAP |
| size | input | 2 | 0 byte, 1 word, 2 long, 3 reserved |
| src_mode | input | 3 | Source addressing mode (0 data reg, 7 immediate) |
| dst_mode | input | 3 | Destination addressing mode (0 data reg) |
| busy | output | 1 | Sequence or error pulse in progress |
| alu_eval | output | 1 | ALU evaluation slot |
| prefetch_cyc | output | 1 | Prefetch bus cycle in progress |
| idle_cyc | output | 1 | Idle bus cycle in progress |
| addr_strobe | output | 1 | Address strobe |
| data_strobe | output | 1 | Data strobe |
| done | output | 1 | Entry to write-back (one clock) |
| err | output | 1 | Unsupported request (one clock) |
| idle_count | output | 2 | Idle cycles chosen for the current pattern |

## Verification
The bench targets the mode-dependent long forms, where the idle-cycle count changes with the source and destination modes.
- Long AND/OR with a data-register destination is driven with data-register, immediate and memory sources. A selector that ignored the source would give the same count for all three.
- Long EOR is driven with a data-register destination. A design that treated it like AND/OR with a non-register source would show a latency 4 clocks short.
- Negate-decimal is driven in both modes.
- Starts are issued while busy and without ready operands. A design that accepted them would restart the sequence or leave `busy` high.
- Invalid op and size codes are issued. A design that let them through would raise `alu_eval` instead of `err`.

// File: rtl/alu_seq_pkg.sv
package alu_seq_pkg;

    localparam int GAP_W = 2;

    localparam logic [2:0] OP_CMP  = 3'd0;
    localparam logic [2:0] OP_AND  = 3'd1;
    localparam logic [2:0] OP_OR   = 3'd2;
    localparam logic [2:0] OP_EOR  = 3'd3;
    localparam logic [2:0] OP_NBCD = 3'd4;
    localparam logic [2:0] OP_SWAP = 3'd5;

    localparam logic [1:0] SZ_LONG = 2'd2;
    localparam logic [1:0] SZ_RSVD = 2'd3;

    localparam logic [2:0] MD_DREG = 3'd0;
    localparam logic [2:0] MD_IMM  = 3'd7;

    typedef enum logic [2:0] {
        S_IDLE,
        S_EVAL,
        S_PREF,
        S_GAP,
        S_WB,
        S_ERR
    } seq_state_e;

    typedef struct packed {
        logic             valid;
        logic [GAP_W-1:0] gaps;
    } pat_s;

endpackage

// File: rtl/seq_pattern_sel.sv
module seq_pattern_sel
    import alu_seq_pkg::*;
(
    input  logic [2:0] op,
    input  logic [1:0] size,
    input  logic [2:0] src_mode,
    input  logic [2:0] dst_mode,
    output pat_s       pat
);
    logic is_long;
    logic dst_dreg;
    logic src_fast;

    assign is_long  = (size == SZ_LONG);
    assign dst_dreg = (dst_mode == MD_DREG);
    assign src_fast = (src_mode == MD_DREG) || (src_mode == MD_IMM);

    always_comb begin
        pat.valid = (size != SZ_RSVD);
        pat.gaps  = '0;
        case (op)
            OP_CMP: begin
                if (is_long) pat.gaps = GAP_W'(1);
            end
            OP_AND, OP_OR: begin
                if (is_long && dst_dreg) pat.gaps = src_fast ? GAP_W'(2) : GAP_W'(1);
            end
            OP_EOR: begin
                if (is_long && dst_dreg) pat.gaps = GAP_W'(2);
            end
            OP_NBCD: begin
                if (src_mode == MD_DREG) pat.gaps = GAP_W'(1);
            end
            OP_SWAP: begin
                pat.gaps = '0;
            end
            default: begin
                pat.valid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/seq_bus_timer.sv
module seq_bus_timer #(
    parameter int CLK_PER_BUS = 4,
    localparam int PH_W = (CLK_PER_BUS > 1) ? $clog2(CLK_PER_BUS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    output logic [PH_W-1:0] phase,
    output logic            last
);
    assign last = run && (phase == PH_W'(CLK_PER_BUS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run || last) phase <= '0;
        else                        phase <= phase + PH_W'(1);
    end
endmodule

// File: rtl/seq_gap_counter.sv
module seq_gap_counter
    import alu_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] load_val,
    input  logic             dec,
    output logic [GAP_W-1:0] left
);
    always_ff @(posedge clk) begin
        if (!rst_n)                      left <= '0;
        else if (load)                   left <= load_val;
        else if (dec && left != '0)      left <= left - GAP_W'(1);
    end
endmodule

// File: rtl/alu_bus_seq.sv
module alu_bus_seq
    import alu_seq_pkg::*;
#(
    parameter int CLK_PER_BUS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             operands_ready,
    input  logic [2:0]       op,
    input  logic [1:0]       size,
    input  logic [2:0]       src_mode,
    input  logic [2:0]       dst_mode,
    output logic             busy,
    output logic             alu_eval,
    output logic             prefetch_cyc,
    output logic             idle_cyc,
    output logic             addr_strobe,
    output logic             data_strobe,
    output logic             done,
    output logic             err,
    output logic [GAP_W-1:0] idle_count
);
    localparam int PH_W = (CLK_PER_BUS > 1) ? $clog2(CLK_PER_BUS) : 1;

    seq_state_e       state_q, state_d;
    pat_s             pat;
    logic             accept;
    logic             run_bus;
    logic             bus_last;
    logic [PH_W-1:0]  phase;
    logic [GAP_W-1:0] gaps_left;
    logic             gap_dec;

    assign accept  = (state_q == S_IDLE) && start && operands_ready;
    assign run_bus = (state_q == S_PREF) || (state_q == S_GAP);
    assign gap_dec = (state_q == S_GAP) && bus_last;

    seq_pattern_sel u_sel (
        .op       (op),
        .size     (size),
        .src_mode (src_mode),
        .dst_mode (dst_mode),
        .pat      (pat)
    );

    seq_bus_timer #(.CLK_PER_BUS(CLK_PER_BUS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_bus),
        .phase (phase),
        .last  (bus_last)
    );

    seq_gap_counter u_gaps (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (pat.valid ? pat.gaps : '0),
        .dec      (gap_dec),
        .left     (gaps_left)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (accept) state_d = pat.valid ? S_EVAL : S_ERR;
            S_EVAL: state_d = S_PREF;
            S_PREF: if (bus_last) state_d = (gaps_left == '0) ? S_WB : S_GAP;
            S_GAP:  if (bus_last && gaps_left == GAP_W'(1)) state_d = S_WB;
            S_WB:   state_d = S_IDLE;
            S_ERR:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            idle_count <= '0;
        end else begin
            state_q <= state_d;
            if (accept) idle_count <= pat.valid ? pat.gaps : '0;
        end
    end

    always_comb begin
        busy         = (state_q != S_IDLE);
        alu_eval     = (state_q == S_EVAL);
        prefetch_cyc = (state_q == S_PREF);
        idle_cyc     = (state_q == S_GAP);
        addr_strobe  = (state_q == S_PREF) && (phase >= PH_W'(1));
        data_strobe  = (state_q == S_PREF) && (phase >= PH_W'(2));
        done         = (state_q == S_WB);
        err          = (state_q == S_ERR);
    end
endmodule

// File: rtl/alu_seq_chk.sv
module alu_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       operands_ready,
    input logic       busy,
    input logic       alu_eval,
    input logic       prefetch_cyc,
    input logic       idle_cyc,
    input logic       addr_strobe,
    input logic       data_strobe,
    input logic       done,
    input logic       err,
    input logic [1:0] idle_count
);
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R4
    gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cyc |-> (!addr_strobe && !data_strobe));

    // R4
    data_in_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_strobe |-> addr_strobe);

    // R3
    eval_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alu_eval |=> (prefetch_cyc && !addr_strobe && !alu_eval));

    // R3
    fetch_after_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prefetch_cyc) |-> $past(alu_eval));

    // R12
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (busy && !alu_eval && !prefetch_cyc && !idle_cyc));

    // R12
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !busy);

    // R13
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !err) |=> busy);

    // R2
    ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(start && operands_ready)) |=> !busy);

    // R11
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(idle_count));
endmodule

bind alu_bus_seq alu_seq_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .operands_ready (operands_ready),
    .busy           (busy),
    .alu_eval       (alu_eval),
    .prefetch_cyc   (prefetch_cyc),
    .idle_cyc       (idle_cyc),
    .addr_strobe    (addr_strobe),
    .data_strobe    (data_strobe),
    .done           (done),
    .err            (err),
    .idle_count     (idle_count)
);

// File: tb/sim_alu_bus_seq.sv
module sim_alu_bus_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       operands_ready = 1'b0;
    logic [2:0] op = '0;
    logic [1:0] size = '0;
    logic [2:0] src_mode = '0;
    logic [2:0] dst_mode = '0;
    logic       busy, alu_eval, prefetch_cyc, idle_cyc;
    logic       addr_strobe, data_strobe, done, err;
    logic [1:0] idle_count;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    alu_bus_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .operands_ready(operands_ready),
        .op(op), .size(size), .src_mode(src_mode), .dst_mode(dst_mode),
        .busy(busy), .alu_eval(alu_eval), .prefetch_cyc(prefetch_cyc),
        .idle_cyc(idle_cyc), .addr_strobe(addr_strobe), .data_strobe(data_strobe),
        .done(done), .err(err), .idle_count(idle_count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one valid request and checks order, timing, strobes and count.
    task automatic run_case(input logic [2:0] o, input logic [1:0] s,
                            input logic [2:0] sm, input logic [2:0] dm,
                            input int n, input string req, input bit poke);
        int idx, done_at, eval_n, pref_n, gap_n, as_n, ds_n, gap_strobe, first_pref, cnt_seen;
        done_at = 0; eval_n = 0; pref_n = 0; gap_n = 0; as_n = 0; ds_n = 0;
        gap_strobe = 0; first_pref = 0; cnt_seen = -1;
        @(negedge clk);
        op = o; size = s; src_mode = sm; dst_mode = dm;
        operands_ready = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        idx = 1;
        while (idx < 100) begin
            if (idx == 1) cnt_seen = int'(idle_count);
            if (alu_eval) eval_n++;
            if (prefetch_cyc) begin
                pref_n++;
                if (first_pref == 0) first_pref = idx;
            end
            if (idle_cyc) begin
                gap_n++;
                if (addr_strobe || data_strobe) gap_strobe++;
            end
            if (addr_strobe) as_n++;
            if (data_strobe) ds_n++;
            if (done) begin
                done_at = idx;
                break;
            end
            if (poke && idx == 3) start = 1'b1;   // R13: start while busy
            if (poke && idx == 4) start = 1'b0;
            @(negedge clk);
            idx++;
        end
        check(done_at == 6 + 4 * n, {req, " latency"}, done_at, 6 + 4 * n);
        check(cnt_seen == n, {req, " idle_count"}, cnt_seen, n);
        check(gap_n == 4 * n, {"R3 idle clocks ", req}, gap_n, 4 * n);
        check(eval_n == 1 && first_pref == 2, "R3 eval before prefetch", first_pref, 2);
        check(pref_n == 4, "R3 prefetch clocks", pref_n, 4);
        check(as_n == 3 && ds_n == 2, "R4 strobe clocks", as_n * 10 + ds_n, 32);
        check(gap_strobe == 0, "R4 idle strobes", gap_strobe, 0);
        @(negedge clk);
        check(!busy && !done, "R11 done pulse then idle", int'(busy), 0);
        check(idle_count == 2'(n), "R11 idle_count hold", int'(idle_count), n);
    endtask

    task automatic run_err(input logic [2:0] o, input logic [1:0] s);
        @(negedge clk);
        op = o; size = s; operands_ready = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(err && busy && !alu_eval && !prefetch_cyc, "R12 error pulse", int'(err), 1);
        @(negedge clk);
        check(!err && !busy && !prefetch_cyc, "R12 back to idle", int'(busy), 0);
    endtask

    task automatic run_not_ready();
        @(negedge clk);
        op = 3'd0; size = 2'd2; operands_ready = 1'b0; start = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(!busy && !alu_eval, "R2 start without ready", int'(busy), 0);
        end
        start = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 50000; i++) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !alu_eval && !prefetch_cyc && !idle_cyc && !addr_strobe &&
              !data_strobe && !done && !err && idle_count == 0, "R1 reset state", int'(busy), 0);
        rst_n = 1'b1;
        // R5
        run_case(3'd0, 2'd0, 3'd0, 3'd0, 0, "R5 cmp.b", 0);
        run_case(3'd1, 2'd1, 3'd2, 3'd0, 0, "R5 and.w", 0);
        run_case(3'd3, 2'd0, 3'd0, 3'd0, 0, "R5 eor.b", 0);
        // R6
        run_case(3'd0, 2'd2, 3'd2, 3'd0, 1, "R6 cmp.l", 0);
        // R7
        run_case(3'd1, 2'd2, 3'd0, 3'd0, 2, "R7 and.l dreg", 0);
        run_case(3'd2, 2'd2, 3'd7, 3'd0, 2, "R7 or.l imm", 0);
        run_case(3'd1, 2'd2, 3'd2, 3'd0, 1, "R7 and.l mem", 0);
        run_case(3'd2, 2'd2, 3'd5, 3'd0, 1, "R7 or.l mem", 0);
        // R8
        run_case(3'd1, 2'd2, 3'd0, 3'd2, 0, "R8 and.l to mem", 0);
        run_case(3'd3, 2'd2, 3'd0, 3'd3, 0, "R8 eor.l to mem", 0);
        // R9
        run_case(3'd3, 2'd2, 3'd0, 3'd0, 2, "R9 eor.l dreg", 0);
        // R10
        run_case(3'd4, 2'd0, 3'd0, 3'd0, 1, "R10 nbcd dreg", 0);
        run_case(3'd4, 2'd0, 3'd2, 3'd0, 0, "R10 nbcd mem", 0);
        run_case(3'd5, 2'd2, 3'd0, 3'd0, 0, "R10 swap", 0);
        // R13
        run_case(3'd3, 2'd2, 3'd0, 3'd0, 2, "R13 restart ignored", 1);
        // R2
        run_not_ready();
        // R12
        run_err(3'd6, 2'd1);
        run_err(3'd7, 2'd0);
        run_err(3'd1, 2'd3);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule